// File: doc/BRIEF.md
# Multi-Mode Quadrature Encoder Counter

This block turns the A, B and Index lines of one incremental encoder into a 24-bit position count. A decode select chooses between a step-and-direction interface (A carries the steps, B the direction) and quadrature decoding at one, two or four counts per encoder cycle. Before decoding, all three inputs are synchronised and passed through a digital glitch filter whose sample rate comes from an 8-bit prescale value.

The count register runs in one of four modes. Free-running mode wraps at the 24-bit limits. Clamp mode holds the count between zero and the preset value. One-shot mode stops after the first wrap. Modulo mode cycles between zero and the preset value. Separate carry and borrow toggle bits change on every wrap, and their XOR extends the count to 25 bits. The preset value can be loaded into the count by a control strobe or by the index input. Index loading is either edge-driven or, in quadrature modes, synchronised to the next decoded count step. A sticky noise flag records illegal quadrature transitions.

All configuration arrives on plain ports and every control action is a one-cycle strobe, so a host register layer can sit in front of the block unchanged.

Top module: `qenc_counter`

## Requirements
- R1: After reset, `count` and `count_ext` are 0, `carry_tog`, `borrow_tog` and `err_flag` are 0, and `up_flag` is 1.
- R2: With `dec_sel`=0 (step/direction), each rising edge of filtered A changes the count by one: up when B is 1, down when B is 0. Falling edges of A and any edge of B do not count.
- R3: Forward motion means A leads B (AB sequence 00,10,11,01). With `dec_sel`=1 (x1), A edges taken while B is 0 count (rising up, falling down). With `dec_sel`=2 (x2), every A edge counts. With `dec_sel`=3 (x4), every A or B edge counts. Without a step, load or clear, the count does not change.
- R4: `up_flag` takes the direction of the most recent decoded step: 1 for up, 0 for down.
- R5: With `cnt_mode`=0 (free-running), counting up from 0xFFFFFF gives 0 and toggles `carry_tog`. Counting down from 0 gives 0xFFFFFF and toggles `borrow_tog`. `count_ext` equals {`carry_tog` XOR `borrow_tog`, `count`}.
- R6: With `cnt_mode`=1 (clamp), an up step at a count of `preset` or more, or a down step at 0, leaves the count and both toggle bits unchanged.
- R7: With `cnt_mode`=2 (one-shot), wraps behave as in R5. After a wrap, further steps are ignored until `ld_preset`, an index load or `clr_count` occurs.
- R8: With `cnt_mode`=3 (modulo), an up step at a count of `preset` or more gives 0 and toggles `carry_tog`. A down step at 0 gives `preset` and toggles `borrow_tog`.
- R9: In a quadrature mode with `ab_en` high, a filtered change of A and B in the same sample sets `err_flag` and does not count. `err_flag` stays set until `clr_err` is strobed.
- R10: While `ab_en` is 0, no input change alters the count, the direction flag or `err_flag`.
- R11: With `idx_preset_en` high and synchronous index off, an index edge that reaches the active level (`idx_pol`=1: rising, 0: falling) loads `preset` into the count. `ld_preset` also loads it. `clr_count` zeroes the count and takes priority over any load, and a load takes priority over a step.
- R12: With `idx_sync_req` high in a quadrature mode, an index edge alone does nothing. A decoded step taken while index is at its active level loads `preset` instead of counting. With `dec_sel`=0 the request is ignored and R11 applies.
- R13: A filtered input follows its raw input only after two consecutive sample ticks agree. Ticks occur every `psc`+1 clock cycles, so a pulse shorter than `psc`+1 cycles is never counted.
- R14: `clr_flags` clears both `carry_tog` and `borrow_tog`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder channel A (raw, asynchronous) |
| enc_b | input | 1 | Encoder channel B (raw, asynchronous) |
| enc_idx | input | 1 | Encoder index (raw, asynchronous) |
| dec_sel | input | 2 | 0 step/direction, 1 x1, 2 x2, 3 x4 |
| cnt_mode | input | 2 | 0 free-running, 1 clamp, 2 one-shot, 3 modulo |
| ab_en | input | 1 | Enables counting from A and B |
| psc | input | 8 | Filter sample period minus one, in clock cycles |
| idx_pol | input | 1 | Active index level (1 high, 0 low) |
| idx_preset_en | input | 1 | Enables preset loading from the index |
| idx_sync_req | input | 1 | Requests index loading synchronised to count steps |
| preset | input | 24 | Reload value and ceiling |
| ld_preset | input | 1 | Strobe: copy preset into count |
| clr_count | input | 1 | Strobe: zero the count |
| clr_flags | input | 1 | Strobe: clear carry and borrow toggles |
| clr_err | input | 1 | Strobe: clear the noise flag |
| count | output | 24 | Current count |
| count_ext | output | 25 | Count extended by carry XOR borrow |
| carry_tog | output | 1 | Toggles on each up-wrap |
| borrow_tog | output | 1 | Toggles on each down-wrap |
| up_flag | output | 1 | Direction of last step (1 up) |
| err_flag | output | 1 | Sticky illegal-transition flag |

## Verification
The bound checker watches, on every cycle, that the count holds without a step, load or clear, that loads take the preset, and that the noise flag is sticky. It also checks that the direction flag follows each decoded step, that disabled inputs produce no steps, and that the clamp and modulo rules hold at the ceiling. Only the bench's scenarios can show end-to-end decode correctness from raw pin waveforms. That covers which edges count in each of the four decode selections, the exact wrap values and toggle-bit histories over long step sequences, the one-shot stop and restart, index polarity and the synchronous-index handoff, and glitch rejection across prescale settings.

// File: rtl/qenc_pkg.sv
// Package: shared encodings for the quadrature encoder counter.
// Assumes: selector ports are 2 bits wide and map directly onto these enums.
package qenc_pkg;

    typedef enum logic [1:0] {
        DEC_STEP_DIR = 2'd0,
        DEC_X1       = 2'd1,
        DEC_X2       = 2'd2,
        DEC_X4       = 2'd3
    } dec_sel_e;

    typedef enum logic [1:0] {
        CM_FREE    = 2'd0,
        CM_CLAMP   = 2'd1,
        CM_ONESHOT = 2'd2,
        CM_MODULO  = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/qenc_in_filter.sv
// Module: qenc_in_filter
// Synchronises NCH asynchronous inputs with two flops each, then filters
// them. A filtered output changes only when two consecutive sample ticks
// see the same synchronised value. Ticks come every psc+1 clock cycles.
// Assumes: psc may change at any time; the divider restarts from its next wrap.
module qenc_in_filter #(
    parameter int NCH   = 3,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   raw_in,
    input  logic [PSC_W-1:0] psc,
    output logic [NCH-1:0]   clean
);

    logic [PSC_W-1:0] div_q;
    logic             smp_tick;

    assign smp_tick = (div_q >= psc);

    // Sample-rate divider: wraps to zero on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (smp_tick) div_q <= '0;
        else               div_q <= div_q + 1'b1;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        logic sync1, sync2, last_smp, cln;

        // Two-flop synchroniser followed by a two-sample agreement filter.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sync1    <= 1'b0;
                sync2    <= 1'b0;
                last_smp <= 1'b0;
                cln      <= 1'b0;
            end else begin
                sync1 <= raw_in[g];
                sync2 <= sync1;
                if (smp_tick) begin
                    last_smp <= sync2;
                    if (sync2 == last_smp) cln <= sync2;
                end
            end
        end

        assign clean[g] = cln;
    end

endmodule

// File: rtl/qenc_decoder.sv
// Module: qenc_decoder
// Turns filtered A/B/Index levels into single-cycle up/down step pulses,
// an illegal-transition pulse and an index-load pulse.
// Assumes: inputs are already synchronous and filtered, so each change
// lasts at least one cycle.
module qenc_decoder
    import qenc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clean_a,
    input  logic     clean_b,
    input  logic     clean_i,
    input  dec_sel_e sel,
    input  logic     ab_en,
    input  logic     idx_pol,
    input  logic     idx_preset_en,
    input  logic     idx_sync_req,
    output logic     step_up,
    output logic     step_dn,
    output logic     bad_move,
    output logic     idx_load
);

    logic prev_a, prev_b, prev_i;
    logic a_chg, b_chg, phase_x;
    logic ev, dir_up, bad;
    logic step_ok, sync_eff, idx_active, idx_edge;

    // Previous filtered levels, tracked every cycle so re-enabling never
    // produces a stale edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
            prev_i <= 1'b0;
        end else begin
            prev_a <= clean_a;
            prev_b <= clean_b;
            prev_i <= clean_i;
        end
    end

    // Edge classification per decode selection.
    always_comb begin
        a_chg   = clean_a ^ prev_a;
        b_chg   = clean_b ^ prev_b;
        phase_x = clean_a ^ clean_b;
        ev      = 1'b0;
        dir_up  = 1'b0;
        bad     = 1'b0;
        unique case (sel)
            DEC_STEP_DIR: begin
                ev     = a_chg & clean_a;
                dir_up = clean_b;
            end
            DEC_X1: begin
                bad    = a_chg & b_chg;
                ev     = a_chg & ~b_chg & ~clean_b;
                dir_up = phase_x;
            end
            DEC_X2: begin
                bad    = a_chg & b_chg;
                ev     = a_chg & ~b_chg;
                dir_up = phase_x;
            end
            DEC_X4: begin
                bad    = a_chg & b_chg;
                ev     = a_chg ^ b_chg;
                dir_up = phase_x ^ b_chg;
            end
        endcase
    end

    assign step_ok  = ab_en & ev;
    assign step_up  = step_ok & dir_up;
    assign step_dn  = step_ok & ~dir_up;
    assign bad_move = ab_en & bad;

    // Index qualification: edge-driven, or gated by a step when synchronous.
    assign sync_eff   = idx_sync_req & (sel != DEC_STEP_DIR);
    assign idx_active = (clean_i == idx_pol);
    assign idx_edge   = (clean_i ^ prev_i) & idx_active;
    assign idx_load   = idx_preset_en &
                        (sync_eff ? (idx_active & step_ok) : idx_edge);

endmodule

// File: rtl/qenc_count_core.sv
// Module: qenc_count_core
// Count register with four wrap/limit modes, carry/borrow toggle bits,
// direction flag, sticky noise flag and one-shot stop state.
// Assumes: step_up and step_dn are never high together.
// Priority: clr_count > reload > step.
module qenc_count_core
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             idx_load,
    input  logic             ld_preset,
    input  logic             clr_count,
    input  logic             clr_flags,
    input  logic             bad_move,
    input  logic             clr_err,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             carry_tog,
    output logic             borrow_tog,
    output logic             up_flag,
    output logic             err_flag
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] nxt;
    logic             hit_c, hit_b;
    logic             halted, blocked, accept, reload;

    assign blocked = halted & (mode == CM_ONESHOT);
    assign accept  = (step_up | step_dn) & ~blocked;
    assign reload  = ld_preset | idx_load;

    // Next count and wrap detection for one step in the selected mode.
    always_comb begin
        nxt   = count;
        hit_c = 1'b0;
        hit_b = 1'b0;
        if (step_up) begin
            unique case (mode)
                CM_FREE, CM_ONESHOT: begin
                    if (count == MAXV) begin nxt = '0; hit_c = 1'b1; end
                    else                      nxt = count + ONE;
                end
                CM_CLAMP: begin
                    if (count < preset) nxt = count + ONE;
                end
                CM_MODULO: begin
                    if (count >= preset) begin nxt = '0; hit_c = 1'b1; end
                    else                        nxt = count + ONE;
                end
            endcase
        end else if (step_dn) begin
            unique case (mode)
                CM_FREE, CM_ONESHOT: begin
                    if (count == '0) begin nxt = MAXV; hit_b = 1'b1; end
                    else                    nxt = count - ONE;
                end
                CM_CLAMP: begin
                    if (count != '0) nxt = count - ONE;
                end
                CM_MODULO: begin
                    if (count == '0) begin nxt = preset; hit_b = 1'b1; end
                    else                    nxt = count - ONE;
                end
            endcase
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)         count <= '0;
        else if (clr_count) count <= '0;
        else if (reload)    count <= preset;
        else if (accept)    count <= nxt;
    end

    // One-shot stop state: set on a wrap, released by any reload or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      halted <= 1'b0;
        else if (clr_count || reload || mode != CM_ONESHOT) halted <= 1'b0;
        else if (accept && (hit_c || hit_b))             halted <= 1'b1;
    end

    // Carry and borrow toggle bits.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_flags) begin
            carry_tog  <= 1'b0;
            borrow_tog <= 1'b0;
        end else if (accept && !clr_count && !reload) begin
            if (hit_c) carry_tog  <= ~carry_tog;
            if (hit_b) borrow_tog <= ~borrow_tog;
        end
    end

    // Direction of the latest decoded step.
    always_ff @(posedge clk) begin
        if (!rst_n)       up_flag <= 1'b1;
        else if (step_up) up_flag <= 1'b1;
        else if (step_dn) up_flag <= 1'b0;
    end

    // Sticky noise flag; a new illegal move wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (bad_move) err_flag <= 1'b1;
        else if (clr_err)  err_flag <= 1'b0;
    end

endmodule

// File: rtl/qenc_counter.sv
// Module: qenc_counter (top)
// One encoder channel: input filter, edge decoder and count core.
// Assumes: all control strobes are synchronous to clk and one cycle long.
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             enc_idx,
    input  logic [1:0]       dec_sel,
    input  logic [1:0]       cnt_mode,
    input  logic             ab_en,
    input  logic [PSC_W-1:0] psc,
    input  logic             idx_pol,
    input  logic             idx_preset_en,
    input  logic             idx_sync_req,
    input  logic [CNT_W-1:0] preset,
    input  logic             ld_preset,
    input  logic             clr_count,
    input  logic             clr_flags,
    input  logic             clr_err,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W:0]   count_ext,
    output logic             carry_tog,
    output logic             borrow_tog,
    output logic             up_flag,
    output logic             err_flag
);

    localparam int NLANE = 3;

    logic [NLANE-1:0] clean;
    logic             step_up, step_dn, bad_move, idx_load;

    qenc_in_filter #(.NCH(NLANE), .PSC_W(PSC_W)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in ({enc_idx, enc_b, enc_a}),
        .psc    (psc),
        .clean  (clean)
    );

    qenc_decoder u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .clean_a       (clean[0]),
        .clean_b       (clean[1]),
        .clean_i       (clean[2]),
        .sel           (dec_sel_e'(dec_sel)),
        .ab_en         (ab_en),
        .idx_pol       (idx_pol),
        .idx_preset_en (idx_preset_en),
        .idx_sync_req  (idx_sync_req),
        .step_up       (step_up),
        .step_dn       (step_dn),
        .bad_move      (bad_move),
        .idx_load      (idx_load)
    );

    qenc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .idx_load   (idx_load),
        .ld_preset  (ld_preset),
        .clr_count  (clr_count),
        .clr_flags  (clr_flags),
        .bad_move   (bad_move),
        .clr_err    (clr_err),
        .mode       (cnt_mode_e'(cnt_mode)),
        .preset     (preset),
        .count      (count),
        .carry_tog  (carry_tog),
        .borrow_tog (borrow_tog),
        .up_flag    (up_flag),
        .err_flag   (err_flag)
    );

    assign count_ext = {carry_tog ^ borrow_tog, count};

endmodule

// File: rtl/qenc_counter_chk.sv
// Module: qenc_counter_chk
// Cycle-by-cycle properties of the counter, attached to the top by bind.
module qenc_counter_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cnt_mode,
    input logic [CNT_W-1:0] preset,
    input logic             ab_en,
    input logic             ld_preset,
    input logic             clr_count,
    input logic             clr_err,
    input logic             step_up,
    input logic             step_dn,
    input logic             idx_load,
    input logic [CNT_W-1:0] count,
    input logic             up_flag,
    input logic             err_flag
);

    assert_count_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up || step_dn || idx_load || ld_preset || clr_count) |=> $stable(count));

    assert_dir_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> up_flag);

    assert_dir_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_dn |=> !up_flag);

    assert_clamp_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd1) && step_up && (count >= preset) &&
        !(idx_load || ld_preset || clr_count) |=> count == $past(count));

    assert_modulo_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode == 2'd3) && step_up && (count >= preset) &&
        !(idx_load || ld_preset || clr_count) |=> count == '0);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !clr_err |=> err_flag);

    assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_en |-> !(step_up || step_dn));

    assert_reload_value_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_preset || idx_load) && !clr_count |=> count == $past(preset));

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_count |=> count == '0);

endmodule

bind qenc_counter qenc_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_mode  (cnt_mode),
    .preset    (preset),
    .ab_en     (ab_en),
    .ld_preset (ld_preset),
    .clr_count (clr_count),
    .clr_err   (clr_err),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .idx_load  (idx_load),
    .count     (count),
    .up_flag   (up_flag),
    .err_flag  (err_flag)
);

// File: tb/test_qenc_counter.sv
`timescale 1ns/1ps
// Bench: sweeps every decode selection against every count mode, then
// directed wrap, one-shot, noise, enable, index and filter scenarios.
module test_qenc_counter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enc_a, enc_b, enc_idx;
    logic [1:0]  dec_sel, cnt_mode;
    logic        ab_en;
    logic [7:0]  psc;
    logic        idx_pol, idx_preset_en, idx_sync_req;
    logic [23:0] preset;
    logic        ld_preset, clr_count, clr_flags, clr_err;
    logic [23:0] count;
    logic [24:0] count_ext;
    logic        carry_tog, borrow_tog, up_flag, err_flag;

    always #5 clk = ~clk;

    qenc_counter i_qenc_counter (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
        .dec_sel(dec_sel), .cnt_mode(cnt_mode), .ab_en(ab_en), .psc(psc),
        .idx_pol(idx_pol), .idx_preset_en(idx_preset_en), .idx_sync_req(idx_sync_req),
        .preset(preset), .ld_preset(ld_preset), .clr_count(clr_count),
        .clr_flags(clr_flags), .clr_err(clr_err), .count(count), .count_ext(count_ext),
        .carry_tog(carry_tog), .borrow_tog(borrow_tog), .up_flag(up_flag),
        .err_flag(err_flag)
    );

    int vectors = 0;
    int miscompares = 0;
    int settle = 8;

    // Bench model state
    logic [23:0] e_cnt;
    logic        e_c, e_b, e_up, e_err, e_halt;
    logic        cur_a, cur_b, cur_i;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "count", 64'(count), 64'(e_cnt));
        check(req, "count_ext", 64'(count_ext), 64'({e_c ^ e_b, e_cnt}));
        check(req, "carry", 64'(carry_tog), 64'(e_c));
        check(req, "borrow", 64'(borrow_tog), 64'(e_b));
        check(req, "up_flag", 64'(up_flag), 64'(e_up));
        check(req, "err_flag", 64'(err_flag), 64'(e_err));
    endtask

    // Expected effect of one decoded step, from R5-R8 and R12.
    task automatic model_step(input bit up);
        e_up = up;
        if (idx_sync_req && dec_sel != 2'd0 && idx_preset_en && (cur_i == idx_pol)) begin
            e_cnt  = preset;
            e_halt = 1'b0;
            return;
        end
        if (cnt_mode == 2'd2 && e_halt) return;
        if (up) begin
            case (cnt_mode)
                2'd0, 2'd2: if (e_cnt == 24'hFFFFFF) begin
                                e_cnt = '0; e_c = ~e_c;
                                if (cnt_mode == 2'd2) e_halt = 1'b1;
                            end else e_cnt = e_cnt + 24'd1;
                2'd1:       if (e_cnt < preset) e_cnt = e_cnt + 24'd1;
                default:    if (e_cnt >= preset) begin e_cnt = '0; e_c = ~e_c; end
                            else e_cnt = e_cnt + 24'd1;
            endcase
        end else begin
            case (cnt_mode)
                2'd0, 2'd2: if (e_cnt == '0) begin
                                e_cnt = 24'hFFFFFF; e_b = ~e_b;
                                if (cnt_mode == 2'd2) e_halt = 1'b1;
                            end else e_cnt = e_cnt - 24'd1;
                2'd1:       if (e_cnt != '0) e_cnt = e_cnt - 24'd1;
                default:    if (e_cnt == '0) begin e_cnt = preset; e_b = ~e_b; end
                            else e_cnt = e_cnt - 24'd1;
            endcase
        end
    endtask

    // Drive new A/B levels, predict the result, wait and check.
    task automatic move(input bit na, input bit nb, input string req);
        bit ac, bc;
        ac = (na != cur_a);
        bc = (nb != cur_b);
        if (ab_en) begin
            if (dec_sel == 2'd0) begin
                if (ac && na) model_step(nb);
            end else if (ac && bc) begin
                e_err = 1'b1;
            end else if (ac) begin
                if (dec_sel >= 2'd2 || (dec_sel == 2'd1 && !nb)) model_step(na ^ nb);
            end else if (bc) begin
                if (dec_sel == 2'd3) model_step(!(na ^ nb));
            end
        end
        enc_a = na; enc_b = nb;
        cur_a = na; cur_b = nb;
        tick(settle);
        check_all(req);
    endtask

    function automatic int phase_of(input bit a, input bit b);
        if (!a && !b) return 0;
        if (a && !b)  return 1;
        if (a && b)   return 2;
        return 3;
    endfunction

    // Quadrature motion: dir +1 forward (A leads B), -1 backward.
    task automatic qmove(input int dir, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            int p;
            p = (phase_of(cur_a, cur_b) + dir + 4) % 4;
            case (p)
                0:       move(1'b0, 1'b0, req);
                1:       move(1'b1, 1'b0, req);
                2:       move(1'b1, 1'b1, req);
                default: move(1'b0, 1'b1, req);
            endcase
        end
    endtask

    // Step/direction pulses: B set first, then A high and low.
    task automatic spulse(input bit up, input int n, input string req);
        move(cur_a, up, req);
        for (int i = 0; i < n; i++) begin
            move(1'b1, up, req);
            move(1'b0, up, req);
        end
    endtask

    task automatic set_idx(input bit v, input string req);
        if (idx_preset_en && !(idx_sync_req && dec_sel != 2'd0) &&
            (v != cur_i) && (v == idx_pol)) begin
            e_cnt = preset; e_halt = 1'b0;
        end
        enc_idx = v; cur_i = v;
        tick(settle);
        check_all(req);
    endtask

    task automatic do_clr_count();
        clr_count = 1'b1; tick(1); clr_count = 1'b0; tick(1);
        e_cnt = '0; e_halt = 1'b0;
    endtask

    task automatic do_ld();
        ld_preset = 1'b1; tick(1); ld_preset = 1'b0; tick(1);
        e_cnt = preset; e_halt = 1'b0;
    endtask

    task automatic do_clr_flags();
        clr_flags = 1'b1; tick(1); clr_flags = 1'b0; tick(1);
        e_c = 1'b0; e_b = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        cnt_mode = m; e_halt = 1'b0; tick(2);
    endtask

    // Watchdog: a hung run is a failed check and still summarises.
    initial begin
        #1_500_000;
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        enc_a = 0; enc_b = 0; enc_idx = 0;
        dec_sel = 0; cnt_mode = 0; ab_en = 1; psc = 0;
        idx_pol = 1; idx_preset_en = 0; idx_sync_req = 0;
        preset = 0; ld_preset = 0; clr_count = 0; clr_flags = 0; clr_err = 0;
        e_cnt = 0; e_c = 0; e_b = 0; e_up = 1; e_err = 0; e_halt = 0;
        cur_a = 0; cur_b = 0; cur_i = 0;
        tick(3);
        check_all("R1 reset");
        rst_n = 1'b1;
        tick(4);
        check_all("R1 after release");

        // Sweep: every decode selection against every count mode.
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 4; m++) begin
                string tag;
                tag = $sformatf("%s/%s", (s == 0) ? "R2" : "R3",
                                (m == 0) ? "R5" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R8");
                dec_sel = 2'(s);
                preset  = 24'd4;
                set_mode(2'(m));
                do_clr_count();
                do_clr_flags();
                check_all(tag);
                if (s == 0) begin
                    spulse(1'b1, 6, tag);
                    spulse(1'b0, 9, tag);
                end else begin
                    qmove(1, 7, tag);
                    qmove(-1, 11, tag);
                end
            end
        end

        // R5: 24-bit top wrap in free-running x4.
        dec_sel = 2'd3; set_mode(2'd0);
        preset = 24'hFFFFFE; do_ld(); check_all("R5 load");
        qmove(1, 3, "R5 up wrap");
        qmove(-1, 3, "R5 down past wrap");

        // R7: one-shot stops after the wrap, restarts after a load.
        set_mode(2'd2); do_clr_flags(); do_ld();
        qmove(1, 4, "R7 stop after carry");
        do_ld(); check_all("R7 reload");
        qmove(1, 1, "R7 counts again");

        // R14: clear toggle bits.
        do_clr_flags(); check_all("R14 flags cleared");

        // R9: simultaneous A/B change.
        set_mode(2'd0); do_clr_count();
        move(!cur_a, !cur_b, "R9 illegal sets error");
        qmove(1, 2, "R9 error sticky");
        clr_err = 1'b1; tick(1); clr_err = 1'b0; tick(1); e_err = 1'b0;
        check_all("R9 error cleared");

        // R10: disabled inputs.
        ab_en = 1'b0; tick(1);
        qmove(1, 3, "R10 disabled no count");
        move(!cur_a, !cur_b, "R10 disabled no error");
        ab_en = 1'b1; tick(2);
        qmove(-1, 2, "R10 re-enabled");

        // R11: edge-driven index loads, both polarities, and priority.
        preset = 24'h000123; idx_preset_en = 1'b0;
        set_idx(1'b1, "R11 index ignored when disabled");
        set_idx(1'b0, "R11 index ignored when disabled");
        idx_preset_en = 1'b1; idx_pol = 1'b1;
        set_idx(1'b1, "R11 rising edge loads");
        qmove(1, 2, "R11 counts from preset");
        idx_pol = 1'b0; tick(2);
        preset = 24'h000456;
        set_idx(1'b0, "R11 falling edge loads");
        set_idx(1'b1, "R11 inactive edge");
        clr_count = 1'b1; ld_preset = 1'b1; tick(1);
        clr_count = 1'b0; ld_preset = 1'b0; tick(1);
        e_cnt = '0;
        check_all("R11 clear beats load");

        // R12: synchronous index in x4 and forced off in step/direction.
        idx_pol = 1'b1; idx_sync_req = 1'b1; preset = 24'h000055;
        set_idx(1'b0, "R12 setup");
        do_clr_count();
        set_idx(1'b1, "R12 edge alone no load");
        qmove(1, 1, "R12 step loads preset");
        set_idx(1'b0, "R12 index inactive");
        qmove(1, 1, "R12 counts normally");
        dec_sel = 2'd0; tick(2);
        do_clr_count();
        set_idx(1'b1, "R12 step/dir uses edge");
        set_idx(1'b0, "R12 step/dir release");
        idx_sync_req = 1'b0; idx_preset_en = 1'b0;

        // R13: glitch filter with prescale.
        psc = 8'd0; settle = 8;
        do_clr_count();
        move(1'b0, 1'b1, "R13 setup dir up");
        enc_a = 1'b1; tick(1); enc_a = 1'b0; tick(8);
        check_all("R13 one-cycle pulse rejected");
        enc_a = 1'b1; tick(3); enc_a = 1'b0; tick(8);
        e_cnt = e_cnt + 24'd1; e_up = 1'b1;
        check_all("R13 three-cycle pulse counted psc 0");
        psc = 8'd3; settle = 20; tick(4);
        enc_a = 1'b1; tick(3); enc_a = 1'b0; tick(20);
        check_all("R13 three-cycle pulse rejected psc 3");
        spulse(1'b1, 2, "R13 slow pulses counted psc 3");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule